// File: doc/BRIEF.md
# Transactional miss acknowledgement collector

Per-core first-level cache line controller for a transactional-memory system with a single outstanding read miss. A core load to an absent line sends a shared-read request to the directory. The directory cannot rule out an in-flight transaction on an uncached line, so it broadcasts the request. Every remote core checks its conflict signature and replies straight to this controller with a positive or a negative acknowledgement. The directory separately returns exclusive data that carries the number of replies to expect.

Replies can overtake the data, so a small signed counter is decremented once per reply and can go below zero. The expected count carried by the data is then added to it. When the line waits in the data-received state with the counter at zero, an all-replies event fires. If every reply was positive, the line becomes exclusive and the load completes. If any reply was negative, the line is dropped and the core is told to retry. In the exclusive state the line is readable but not writable: a store raises an upgrade request instead. A forwarded read from another core downgrades the line to shared and returns the data.

Top module: `txn_miss_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, state_o reads 0 (absent) and gets_o, done_o, retry_o, upgrade_o and fwd_data_o are all low.
- R2: A load (load_req_i) with state_o = 0 sets state_o to 1 (waiting) and pulses gets_o for one cycle, both visible one cycle after the request is sampled.
- R3: In state 1, each reply (resp_vld_i) decrements a 6-bit signed counter that was cleared when the miss started, so replies arriving before the data leave the line in state 1.
- R4: Data (data_vld_i) in state 1 moves state_o to 2 (data received) one cycle later and adds data_ack_cnt_i to the counter.
- R5: In state 2 with the counter at zero and no negative reply seen, the next cycle shows state_o = 3 (exclusive) with a one-cycle done_o pulse.
- R6: If any reply of the miss had resp_nack_i high, the zero-counter cycle in state 2 instead returns state_o to 0 with a one-cycle retry_o pulse and no done_o.
- R7: Replies that arrive after the data keep decrementing the counter in state 2, and completion waits for the counter to reach zero.
- R8: A load in state 3 or 4 (shared) pulses done_o one cycle later and leaves the state unchanged.
- R9: A store (store_req_i) in state 3 or 4 pulses upgrade_o one cycle later, gives no done_o and leaves the state unchanged.
- R10: A forwarded read (fwd_gets_i) in state 3 moves state_o to 4 with a one-cycle fwd_data_o pulse. In any other state it has no effect.
- R11: Replies, data and stores in state 0 have no effect: the state stays 0 and no output pulses.
- R12: A load while a miss is outstanding (state 1 or 2) is ignored and sends no second gets_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_req_i | input | 1 | Core load request |
| store_req_i | input | 1 | Core store request |
| resp_vld_i | input | 1 | Remote conflict-check reply valid |
| resp_nack_i | input | 1 | Reply is a negative acknowledgement |
| data_vld_i | input | 1 | Exclusive data from directory |
| data_ack_cnt_i | input | 4 | Replies expected, carried by the data |
| fwd_gets_i | input | 1 | Forwarded read from another core |
| state_o | output | 3 | Line state: 0 absent, 1 waiting, 2 data received, 3 exclusive, 4 shared |
| gets_o | output | 1 | Shared-read request to directory |
| done_o | output | 1 | Load complete |
| retry_o | output | 1 | Load must be retried |
| upgrade_o | output | 1 | Write-permission request |
| fwd_data_o | output | 1 | Data returned for forwarded read |

## Verification
Every input message is sampled on one edge, and its direct result (gets_o, upgrade_o, fwd_data_o, a load-hit done_o, or the move from state 1 to 2) is due one cycle later. Completion or retry takes a second cycle after the counter reaches zero in state 2. The driver queues each expected pulse together with the state that must accompany it, before it applies the stimulus. The monitor samples on the falling edge and pops one item for every pulse it sees, so a pulse that comes early, comes late or should not appear at all is reported. State checks follow each message at the same falling edge, after exactly one rising edge.

// File: rtl/txn_miss_pkg.sv
package txn_miss_pkg;
  typedef enum logic [2:0] {
    ST_NP  = 3'd0,
    ST_IS  = 3'd1,
    ST_ISE = 3'd2,
    ST_E   = 3'd3,
    ST_S   = 3'd4
  } line_st_e;
endpackage

// File: rtl/txn_ack_counter.sv
module txn_ack_counter #(
  parameter int CNT_W = 6,
  parameter int EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             dec_i,
  input  logic             add_i,
  input  logic [EXP_W-1:0] add_val_i,
  output logic             zero_o
);
  localparam int PAD_W = CNT_W - EXP_W;

  logic signed [CNT_W-1:0] cnt_q, cnt_d, add_term, dec_term;

  always_comb begin
    add_term = add_i ? signed'({{PAD_W{1'b0}}, add_val_i}) : '0;
    dec_term = dec_i ? CNT_W'(1) : '0;
    cnt_d    = clr_i ? '0 : cnt_q + add_term - dec_term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/txn_line_fsm.sv
module txn_line_fsm
  import txn_miss_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_req_i,
  input  logic     store_req_i,
  input  logic     resp_vld_i,
  input  logic     resp_nack_i,
  input  logic     data_vld_i,
  input  logic     fwd_gets_i,
  input  logic     zero_i,
  output logic     clr_o,
  output logic     dec_o,
  output logic     add_o,
  output line_st_e st_o,
  output logic     gets_o,
  output logic     done_o,
  output logic     retry_o,
  output logic     upgrade_o,
  output logic     fwd_data_o
);
  line_st_e st_q, st_d;
  logic nack_q, nack_d;
  logic gets_d, done_d, retry_d, upg_d, fwd_d;

  always_comb begin
    st_d    = st_q;
    nack_d  = nack_q;
    clr_o   = 1'b0;
    dec_o   = 1'b0;
    add_o   = 1'b0;
    gets_d  = 1'b0;
    done_d  = 1'b0;
    retry_d = 1'b0;
    upg_d   = 1'b0;
    fwd_d   = 1'b0;
    unique case (st_q)
      ST_NP: begin
        if (load_req_i) begin
          st_d   = ST_IS;
          clr_o  = 1'b1;
          nack_d = 1'b0;
          gets_d = 1'b1;
        end
      end
      ST_IS: begin
        dec_o = resp_vld_i;
        if (resp_vld_i && resp_nack_i) nack_d = 1'b1;
        if (data_vld_i) begin
          add_o = 1'b1;
          st_d  = ST_ISE;
        end
      end
      ST_ISE: begin
        if (zero_i) begin
          // all replies counted
          if (nack_q) begin
            st_d    = ST_NP;
            retry_d = 1'b1;
          end else begin
            st_d   = ST_E;
            done_d = 1'b1;
          end
        end else begin
          dec_o = resp_vld_i;
          if (resp_vld_i && resp_nack_i) nack_d = 1'b1;
        end
      end
      ST_E, ST_S: begin
        done_d = load_req_i;
        upg_d  = store_req_i;
        if (st_q == ST_E && fwd_gets_i) begin
          st_d  = ST_S;
          fwd_d = 1'b1;
        end
      end
      default: st_d = ST_NP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_NP;
      nack_q     <= 1'b0;
      gets_o     <= 1'b0;
      done_o     <= 1'b0;
      retry_o    <= 1'b0;
      upgrade_o  <= 1'b0;
      fwd_data_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      nack_q     <= nack_d;
      gets_o     <= gets_d;
      done_o     <= done_d;
      retry_o    <= retry_d;
      upgrade_o  <= upg_d;
      fwd_data_o <= fwd_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/txn_miss_ctrl.sv
module txn_miss_ctrl #(
  parameter int NUM_CORES = 16,
  parameter int CNT_W     = 6,
  parameter int EXP_W     = $clog2(NUM_CORES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_req_i,
  input  logic             store_req_i,
  input  logic             resp_vld_i,
  input  logic             resp_nack_i,
  input  logic             data_vld_i,
  input  logic [EXP_W-1:0] data_ack_cnt_i,
  input  logic             fwd_gets_i,
  output logic [2:0]       state_o,
  output logic             gets_o,
  output logic             done_o,
  output logic             retry_o,
  output logic             upgrade_o,
  output logic             fwd_data_o
);
  import txn_miss_pkg::*;

  logic     clr, dec, add, zero;
  line_st_e st;

  txn_ack_counter #(
    .CNT_W(CNT_W),
    .EXP_W(EXP_W)
  ) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .dec_i    (dec),
    .add_i    (add),
    .add_val_i(data_ack_cnt_i),
    .zero_o   (zero)
  );

  txn_line_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_req_i (load_req_i),
    .store_req_i(store_req_i),
    .resp_vld_i (resp_vld_i),
    .resp_nack_i(resp_nack_i),
    .data_vld_i (data_vld_i),
    .fwd_gets_i (fwd_gets_i),
    .zero_i     (zero),
    .clr_o      (clr),
    .dec_o      (dec),
    .add_o      (add),
    .st_o       (st),
    .gets_o     (gets_o),
    .done_o     (done_o),
    .retry_o    (retry_o),
    .upgrade_o  (upgrade_o),
    .fwd_data_o (fwd_data_o)
  );

  assign state_o = st;
endmodule

// File: rtl/txn_miss_chk.sv
module txn_miss_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       store_req_i,
  input logic [2:0] state_o,
  input logic       gets_o,
  input logic       done_o,
  input logic       retry_o,
  input logic       upgrade_o,
  input logic       fwd_data_o
);
  AST_GETS_ENTERS_IS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gets_o |-> state_o == 3'd1); // R2
  AST_ISE_FROM_IS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |-> $past(state_o) == 3'd1); // R4
  AST_DONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_o == 3'd3 || state_o == 3'd4)); // R5
  AST_EXCL_FROM_ISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2 && done_o)); // R5
  AST_RETRY_IN_NP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (state_o == 3'd0 && $past(state_o) == 3'd2)); // R6
  AST_DONE_RETRY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && retry_o)); // R6
  AST_STORE_UPGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd3 || state_o == 3'd4) && store_req_i) |=> upgrade_o); // R9
  AST_FWD_DOWNGRADE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_data_o |-> (state_o == 3'd4 && $past(state_o) == 3'd3)); // R10
endmodule

bind txn_miss_ctrl txn_miss_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .store_req_i(store_req_i),
  .state_o    (state_o),
  .gets_o     (gets_o),
  .done_o     (done_o),
  .retry_o    (retry_o),
  .upgrade_o  (upgrade_o),
  .fwd_data_o (fwd_data_o)
);

// File: tb/test_txn_miss_ctrl.sv
`timescale 1ns/1ps
module test_txn_miss_ctrl;
  localparam logic [4:0] EV_GETS = 5'b10000;
  localparam logic [4:0] EV_DONE = 5'b01000;
  localparam logic [4:0] EV_RTRY = 5'b00100;
  localparam logic [4:0] EV_UPG  = 5'b00010;
  localparam logic [4:0] EV_FWD  = 5'b00001;

  typedef struct {
    logic [4:0] ev;
    logic [2:0] st;
    string      req;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic load_req_i = 0, store_req_i = 0, resp_vld_i = 0, resp_nack_i = 0;
  logic data_vld_i = 0, fwd_gets_i = 0;
  logic [3:0] data_ack_cnt_i = '0;
  logic [2:0] state_o;
  logic gets_o, done_o, retry_o, upgrade_o, fwd_data_o;

  int checks = 0, failures = 0;
  exp_t sb[$];

  always #2 clk_i = ~clk_i;

  txn_miss_ctrl i_txn_miss_ctrl (
    .clk_i, .rst_ni, .load_req_i, .store_req_i, .resp_vld_i, .resp_nack_i,
    .data_vld_i, .data_ack_cnt_i, .fwd_gets_i, .state_o, .gets_o, .done_o,
    .retry_o, .upgrade_o, .fwd_data_o
  );

  // monitor: every output pulse must match the head of the scoreboard
  always @(negedge clk_i) begin
    logic [4:0] ev;
    ev = {gets_o, done_o, retry_o, upgrade_o, fwd_data_o};
    if (rst_ni && ev != '0) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL unexpected pulse: actual ev=%b st=%0d expected none", ev, state_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (ev != e.ev || state_o != e.st) begin
          failures++;
          $display("FAIL %s: actual ev=%b st=%0d expected ev=%b st=%0d",
                   e.req, ev, state_o, e.ev, e.st);
        end
      end
    end
  end

  task automatic push(input logic [4:0] ev, input logic [2:0] st, input string req);
    exp_t e;
    e.ev = ev; e.st = st; e.req = req;
    sb.push_back(e);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic send(input bit ld, input bit stq, input bit rv, input bit rn,
                      input bit dv, input logic [3:0] dc, input bit fw);
    load_req_i = ld; store_req_i = stq; resp_vld_i = rv; resp_nack_i = rn;
    data_vld_i = dv; data_ack_cnt_i = dc; fwd_gets_i = fw;
    @(negedge clk_i);
    load_req_i = 0; store_req_i = 0; resp_vld_i = 0; resp_nack_i = 0;
    data_vld_i = 0; data_ack_cnt_i = '0; fwd_gets_i = 0;
  endtask

  task automatic chk_state(input logic [2:0] exp, input string req);
    checks++;
    if (state_o !== exp) begin
      failures++;
      $display("FAIL %s: actual state=%0d expected %0d", req, state_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    step();
    step();
    rst_ni = 1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk_i);
    chk_state(3'd0, "R1 in reset");
    do_reset();
    chk_state(3'd0, "R1 after reset");
    checks++;
    if ({gets_o, done_o, retry_o, upgrade_o, fwd_data_o} !== 5'b0) begin
      failures++;
      $display("FAIL R1: actual outputs=%b expected 00000",
               {gets_o, done_o, retry_o, upgrade_o, fwd_data_o});
    end

    // full broadcast, replies before data
    push(EV_GETS, 3'd1, "R2 gets");
    send(1, 0, 0, 0, 0, 0, 0);
    chk_state(3'd1, "R2 state");
    for (int i = 0; i < 15; i++) send(0, 0, 1, 0, 0, 0, 0);
    chk_state(3'd1, "R3 replies before data");
    send(0, 0, 0, 0, 1, 4'd15, 0);
    chk_state(3'd2, "R4 data received");
    push(EV_DONE, 3'd3, "R5 completion");
    step();
    chk_state(3'd3, "R5 exclusive");
    push(EV_UPG, 3'd3, "R9 store in E");
    send(0, 1, 0, 0, 0, 0, 0);
    chk_state(3'd3, "R9 state kept");
    push(EV_DONE, 3'd3, "R8 hit in E");
    send(1, 0, 0, 0, 0, 0, 0);
    push(EV_FWD, 3'd4, "R10 forward");
    send(0, 0, 0, 0, 0, 0, 1);
    chk_state(3'd4, "R10 shared");
    push(EV_DONE, 3'd4, "R8 hit in S");
    send(1, 0, 0, 0, 0, 0, 0);
    push(EV_UPG, 3'd4, "R9 store in S");
    send(0, 1, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1);
    chk_state(3'd4, "R10 forward in S ignored");

    // data before replies
    do_reset();
    push(EV_GETS, 3'd1, "R2 gets");
    send(1, 0, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 1, 4'd3, 0);
    chk_state(3'd2, "R7 data first");
    send(0, 0, 1, 0, 0, 0, 0);
    send(0, 0, 1, 0, 0, 0, 0);
    chk_state(3'd2, "R7 waiting for last reply");
    send(1, 0, 0, 0, 0, 0, 0);
    chk_state(3'd2, "R12 load ignored");
    push(EV_DONE, 3'd3, "R7 completion");
    send(0, 0, 1, 0, 0, 0, 0);
    step();
    chk_state(3'd3, "R7 exclusive");

    // negative reply before data
    do_reset();
    push(EV_GETS, 3'd1, "R2 gets");
    send(1, 0, 0, 0, 0, 0, 0);
    send(0, 0, 1, 0, 0, 0, 0);
    send(0, 0, 1, 1, 0, 0, 0);
    send(0, 0, 1, 0, 0, 0, 0);
    push(EV_RTRY, 3'd0, "R6 retry");
    send(0, 0, 0, 0, 1, 4'd3, 0);
    step();
    chk_state(3'd0, "R6 back to absent");
    send(0, 0, 1, 0, 0, 0, 0);
    send(0, 0, 0, 0, 1, 4'd5, 0);
    send(0, 1, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 0, 0, 1);
    chk_state(3'd0, "R11 absent ignores messages");

    // negative reply after data
    push(EV_GETS, 3'd1, "R2 gets");
    send(1, 0, 0, 0, 0, 0, 0);
    send(0, 0, 0, 0, 1, 4'd2, 0);
    send(0, 0, 1, 0, 0, 0, 0);
    chk_state(3'd2, "R7 one reply left");
    push(EV_RTRY, 3'd0, "R6 late nack retry");
    send(0, 0, 1, 1, 0, 0, 0);
    step();
    chk_state(3'd0, "R6 absent after late nack");

    step();
    step();
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual pending=%0d expected 0", sb.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule